// File: doc/BRIEF.md
# Open-Page Burst Picker for Best-Effort Memory Clients

This block sits in front of an SDRAM command sequencer and decides which pending burst goes next. Clients push single bursts, each carrying a bank number, a row address, a read/write flag and a one-bit urgency flag. The block keeps them in a small slot store and remembers, for every bank, which row was last opened. Rows are never closed by this block, so a later burst to the same row needs no activate.

Whenever the downstream sequencer can take a command (`issue_en` high) and at least one burst is pending, the block picks one burst and presents it one cycle later. The burst is tagged with a flag that says whether the sequencer must precharge and activate first. The choice follows a fixed ladder. A burst that has waited too long comes first. Then come urgent bursts, then bursts that hit an open row. Among those hits, bursts that keep the data bus in its present direction win. Among misses, reads win over writes. Any remaining tie goes to the burst that has waited longest, and then to the lowest slot.

Top module: `olsched_top`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` is 0 and `req_ready` is 1. After reset every bank has no open row, and the last bus direction counts as read.
- R2: A push (`req_valid` and `req_ready` high at a clock edge) is stored in the lowest-numbered slot that was free before that edge. `req_ready` is 0 exactly when all DEPTH slots are occupied. A push while `req_ready` is 0 is dropped and never issued.
- R3: If `issue_en` is 1 and at least one slot is occupied at an edge, the chosen burst appears on `out_bank`, `out_row`, `out_write` and `out_prio` with `out_valid` = 1 in the following cycle, and it leaves its slot. Otherwise `out_valid` is 0 in the following cycle. A burst pushed at an edge can be chosen no earlier than the next edge.
- R4: A pending burst with `req_prio` = 1 is chosen before any burst with `req_prio` = 0, unless the rule in R9 applies.
- R5: When urgency is equal, a burst whose row equals its bank's open row (a hit) is chosen before a miss.
- R6: Among hits with equal urgency, a burst whose `req_write` equals the direction of the last issued burst (0 = read, 1 = write) is chosen first.
- R7: Among misses with equal urgency, reads (`req_write` = 0) are chosen before writes.
- R8: Remaining ties go to the burst with the larger wait count. The wait count is 0 in the cycle after the push, rises by one at each edge the burst stays pending, and saturates at AGE_LIMIT. Equal wait counts go to the lowest slot.
- R9: A burst whose wait count has reached AGE_LIMIT outranks every burst that has not reached it, whatever their urgency, hit or direction.
- R10: `out_miss` is 1 when the issued burst's bank had no open row or a different open row. Issuing a burst makes its row the bank's open row, and no other event changes the open rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Push a burst this cycle |
| req_bank | input | $clog2(BANKS) | Target bank of the pushed burst |
| req_row | input | ROW_W | Target row of the pushed burst |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_prio | input | 1 | 1 = urgent client |
| req_ready | output | 1 | A free slot exists |
| issue_en | input | 1 | Sequencer can accept a burst this cycle |
| out_valid | output | 1 | A burst was issued at the last edge |
| out_bank | output | $clog2(BANKS) | Bank of the issued burst |
| out_row | output | ROW_W | Row of the issued burst |
| out_write | output | 1 | Direction of the issued burst |
| out_prio | output | 1 | Urgency of the issued burst |
| out_miss | output | 1 | Precharge and activate needed before this burst |

## Verification
The directed cases each set up a pair of bursts that is separated by only one rung of the ladder. Examples are an urgent write miss against an older read, a younger write hit against an older read miss, and two hits with opposite directions after a read. A picker that had two rungs swapped would issue the other burst first. One case sets the wait order against the slot order. A design that ranked slots above waiting time would then issue the newer burst. The starvation case keeps a stream of urgent bursts pending and expects the old normal burst on exactly the step its count saturates. A design with an off-by-one limit or a missing override would issue it late or never. Long random runs with few rows and banks check open-row tracking, the precharge flag, full-store dropping and slot reuse against a reference model written from the requirements.

// File: rtl/olsched_pkg.sv
package olsched_pkg;

    // Direction of the most recently issued burst on the data bus.
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Rank fields ahead of the wait count in the selection key.
    localparam int unsigned RANK_FLAGS = 5;

endpackage

// File: rtl/olsched_queue.sv
module olsched_queue #(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned ROW_W     = 8,
    parameter int unsigned AGE_LIMIT = 15,
    parameter int unsigned AGE_W     = $clog2(AGE_LIMIT + 1),
    parameter int unsigned IDX_W     = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [BANK_W-1:0]                push_bank,
    input  logic [ROW_W-1:0]                 push_row,
    input  logic                             push_write,
    input  logic                             push_prio,
    input  logic                             pop,
    input  logic [IDX_W-1:0]                 pop_idx,
    output logic [DEPTH-1:0]                 slot_valid,
    output logic [DEPTH-1:0][BANK_W-1:0]     slot_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]      slot_row,
    output logic [DEPTH-1:0]                 slot_write,
    output logic [DEPTH-1:0]                 slot_prio,
    output logic [DEPTH-1:0][AGE_W-1:0]      slot_age,
    output logic                             full
);

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              wr;
        logic              prio;
        logic [AGE_W-1:0]  age;
    } slot_t;

    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(AGE_LIMIT);

    slot_t [DEPTH-1:0] slot_d, slot_q;
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!slot_q[i].vld && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_q[i].vld) begin
                if (pop && (pop_idx == IDX_W'(i))) begin
                    slot_d[i].vld = 1'b0;
                end else if (slot_q[i].age != AGE_SAT) begin
                    slot_d[i].age = slot_q[i].age + 1'b1;
                end
            end
        end
        if (push && free_found) begin
            slot_d[free_idx].vld  = 1'b1;
            slot_d[free_idx].bank = push_bank;
            slot_d[free_idx].row  = push_row;
            slot_d[free_idx].wr   = push_write;
            slot_d[free_idx].prio = push_prio;
            slot_d[free_idx].age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_out
            assign slot_valid[g] = slot_q[g].vld;
            assign slot_bank[g]  = slot_q[g].bank;
            assign slot_row[g]   = slot_q[g].row;
            assign slot_write[g] = slot_q[g].wr;
            assign slot_prio[g]  = slot_q[g].prio;
            assign slot_age[g]   = slot_q[g].age;
        end
    endgenerate

    assign full = !free_found;

endmodule

// File: rtl/olsched_rowtrack.sv
module olsched_rowtrack #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned BANK_W = $clog2(BANKS),
    parameter int unsigned ROW_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd,
    input  logic [BANK_W-1:0]            upd_bank,
    input  logic [ROW_W-1:0]             upd_row,
    output logic [BANKS-1:0]             open_vld,
    output logic [BANKS-1:0][ROW_W-1:0]  open_row
);

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
    } bank_t;

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            bank_t bank_d, bank_q;

            always_comb begin
                bank_d = bank_q;
                if (upd && (upd_bank == BANK_W'(b))) begin
                    bank_d.vld = 1'b1;
                    bank_d.row = upd_row;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q <= '0;
                end else begin
                    bank_q <= bank_d;
                end
            end

            assign open_vld[b] = bank_q.vld;
            assign open_row[b] = bank_q.row;
        end
    endgenerate

endmodule

// File: rtl/olsched_picker.sv
module olsched_picker
    import olsched_pkg::*;
#(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned BANKS     = 4,
    parameter int unsigned BANK_W    = $clog2(BANKS),
    parameter int unsigned ROW_W     = 8,
    parameter int unsigned AGE_LIMIT = 15,
    parameter int unsigned AGE_W     = $clog2(AGE_LIMIT + 1),
    parameter int unsigned IDX_W     = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                 slot_valid,
    input  logic [DEPTH-1:0][BANK_W-1:0]     slot_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]      slot_row,
    input  logic [DEPTH-1:0]                 slot_write,
    input  logic [DEPTH-1:0]                 slot_prio,
    input  logic [DEPTH-1:0][AGE_W-1:0]      slot_age,
    input  logic [BANKS-1:0]                 open_vld,
    input  logic [BANKS-1:0][ROW_W-1:0]      open_row,
    input  dir_e                             cur_dir,
    output logic                             any,
    output logic [IDX_W-1:0]                 sel_idx,
    output logic                             sel_hit
);

    localparam int unsigned KEY_W = RANK_FLAGS + AGE_W;
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(AGE_LIMIT);

    logic [DEPTH-1:0][KEY_W-1:0] key;
    logic [DEPTH-1:0]            hit;
    logic [KEY_W-1:0]            best_key;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_key
            logic starved;
            logic same_dir;
            assign hit[g]    = open_vld[slot_bank[g]] &&
                               (open_row[slot_bank[g]] == slot_row[g]);
            assign starved   = (slot_age[g] == AGE_SAT);
            assign same_dir  = (slot_write[g] == (cur_dir == DIR_WR));
            // Rank ladder, most significant first.
            assign key[g] = {starved, slot_prio[g], hit[g],
                             hit[g] & same_dir, ~slot_write[g], slot_age[g]};
        end
    endgenerate

    always_comb begin
        any      = 1'b0;
        best_key = '0;
        sel_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_valid[i] && (!any || (key[i] > best_key))) begin
                any      = 1'b1;
                best_key = key[i];
                sel_idx  = IDX_W'(i);
            end
        end
    end

    assign sel_hit = hit[sel_idx];

endmodule

// File: rtl/olsched_top.sv
module olsched_top
    import olsched_pkg::*;
#(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned BANKS     = 4,
    parameter int unsigned ROW_W     = 8,
    parameter int unsigned AGE_LIMIT = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(BANKS)-1:0]   req_bank,
    input  logic [ROW_W-1:0]           req_row,
    input  logic                       req_write,
    input  logic                       req_prio,
    output logic                       req_ready,
    input  logic                       issue_en,
    output logic                       out_valid,
    output logic [$clog2(BANKS)-1:0]   out_bank,
    output logic [ROW_W-1:0]           out_row,
    output logic                       out_write,
    output logic                       out_prio,
    output logic                       out_miss
);

    localparam int unsigned BANK_W = $clog2(BANKS);
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned AGE_W  = $clog2(AGE_LIMIT + 1);

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              wr;
        logic              prio;
        logic              miss;
        dir_e              dir;
    } issue_t;

    logic [DEPTH-1:0]                 slot_valid;
    logic [DEPTH-1:0][BANK_W-1:0]     slot_bank;
    logic [DEPTH-1:0][ROW_W-1:0]      slot_row;
    logic [DEPTH-1:0]                 slot_write;
    logic [DEPTH-1:0]                 slot_prio;
    logic [DEPTH-1:0][AGE_W-1:0]      slot_age;
    logic                             full;
    logic [BANKS-1:0]                 open_vld;
    logic [BANKS-1:0][ROW_W-1:0]      open_row;
    logic                             any;
    logic [IDX_W-1:0]                 sel_idx;
    logic                             sel_hit;
    logic                             fire;
    issue_t                           iss_d, iss_q;

    assign fire = issue_en && any;

    olsched_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid), .push_bank(req_bank), .push_row(req_row),
        .push_write(req_write), .push_prio(req_prio),
        .pop(fire), .pop_idx(sel_idx),
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row),
        .slot_write(slot_write), .slot_prio(slot_prio), .slot_age(slot_age),
        .full(full)
    );

    olsched_rowtrack #(
        .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n),
        .upd(fire), .upd_bank(slot_bank[sel_idx]), .upd_row(slot_row[sel_idx]),
        .open_vld(open_vld), .open_row(open_row)
    );

    olsched_picker #(
        .DEPTH(DEPTH), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row),
        .slot_write(slot_write), .slot_prio(slot_prio), .slot_age(slot_age),
        .open_vld(open_vld), .open_row(open_row), .cur_dir(iss_q.dir),
        .any(any), .sel_idx(sel_idx), .sel_hit(sel_hit)
    );

    always_comb begin
        iss_d     = iss_q;
        iss_d.vld = fire;
        if (fire) begin
            iss_d.bank = slot_bank[sel_idx];
            iss_d.row  = slot_row[sel_idx];
            iss_d.wr   = slot_write[sel_idx];
            iss_d.prio = slot_prio[sel_idx];
            iss_d.miss = !sel_hit;
            iss_d.dir  = slot_write[sel_idx] ? DIR_WR : DIR_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q     <= '0;
            iss_q.dir <= DIR_RD;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign req_ready = !full;
    assign out_valid = iss_q.vld;
    assign out_bank  = iss_q.bank;
    assign out_row   = iss_q.row;
    assign out_write = iss_q.wr;
    assign out_prio  = iss_q.prio;
    assign out_miss  = iss_q.miss;

endmodule

// File: rtl/olsched_chk.sv
module olsched_chk #(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              issue_en,
    input logic              out_valid,
    input logic [BANK_W-1:0] out_bank,
    input logic [ROW_W-1:0]  out_row,
    input logic              out_miss
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && req_ready)); // R1

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !issue_en) |=> !req_ready); // R2

    AST_ISSUE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(issue_en)); // R3

    AST_FULL_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_en) && $past(!req_ready) && $past(rst_n)) |-> out_valid); // R3

    AST_REPEAT_ROW_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && $past(rst_n) &&
         (out_bank == $past(out_bank)) && (out_row == $past(out_row)))
        |-> !out_miss); // R10

endmodule

bind olsched_top olsched_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .issue_en(issue_en),
    .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row),
    .out_miss(out_miss)
);

// File: tb/tb_olsched_top.sv
module tb_olsched_top;

    localparam int DEPTH = 8;
    localparam int BANKS = 4;
    localparam int ROW_W = 8;
    localparam int LIM   = 15;
    localparam int BW    = $clog2(BANKS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [BW-1:0]    req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic             req_write = 1'b0;
    logic             req_prio = 1'b0;
    logic             req_ready;
    logic             issue_en = 1'b0;
    logic             out_valid;
    logic [BW-1:0]    out_bank;
    logic [ROW_W-1:0] out_row;
    logic             out_write;
    logic             out_prio;
    logic             out_miss;

    always #10 clk = ~clk;

    olsched_top #(.DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .AGE_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_write(req_write), .req_prio(req_prio),
        .req_ready(req_ready), .issue_en(issue_en), .out_valid(out_valid),
        .out_bank(out_bank), .out_row(out_row), .out_write(out_write),
        .out_prio(out_prio), .out_miss(out_miss)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    bit m_vld [DEPTH];
    int m_bank[DEPTH];
    int m_row [DEPTH];
    bit m_wr  [DEPTH];
    bit m_pr  [DEPTH];
    int m_age [DEPTH];
    bit o_vld [BANKS];
    int o_row [BANKS];
    bit m_dir = 1'b0;
    bit e_vld = 1'b0;
    int e_bank, e_row;
    bit e_wr, e_pr, e_miss;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_full();
        for (int i = 0; i < DEPTH; i++) if (!m_vld[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_key(input int i);
        bit h, st;
        h  = o_vld[m_bank[i]] && (o_row[m_bank[i]] == m_row[i]);
        st = (m_age[i] == LIM);
        return (int'(st) << 10) | (int'(m_pr[i]) << 9) | (int'(h) << 8) |
               (int'(h && (m_wr[i] == m_dir)) << 7) | (int'(!m_wr[i]) << 6) | m_age[i];
    endfunction

    function automatic int m_pick();
        int best = -1;
        for (int i = 0; i < DEPTH; i++)
            if (m_vld[i] && (best < 0 || m_key(i) > m_key(best))) best = i;
        return best;
    endfunction

    // One clock: check last results, drive, advance model, cross the edge.
    task automatic step(input bit psh, input int bk, input int rw, input bit wr,
                        input bit pr, input bit iss);
        int s, fr;
        bit full;
        chk("R3 valid", out_valid, e_vld);
        if (e_vld) begin
            chk("R3 bank", out_bank, e_bank);
            chk("R3 row", out_row, e_row);
            chk("R3 write", out_write, e_wr);
            chk("R4 prio", out_prio, e_pr);
            chk("R10 miss", out_miss, e_miss);
        end
        full = m_full();
        chk("R2 ready", req_ready, !full);
        req_valid = psh; req_bank = BW'(bk); req_row = ROW_W'(rw);
        req_write = wr;  req_prio = pr;      issue_en = iss;
        s = m_pick();
        fr = -1;
        for (int i = 0; i < DEPTH; i++) if (!m_vld[i] && fr < 0) fr = i;
        e_vld = iss && (s >= 0);
        for (int i = 0; i < DEPTH; i++)
            if (m_vld[i] && !(e_vld && i == s) && m_age[i] < LIM) m_age[i]++;
        if (e_vld) begin
            e_bank = m_bank[s]; e_row = m_row[s]; e_wr = m_wr[s]; e_pr = m_pr[s];
            e_miss = !(o_vld[e_bank] && o_row[e_bank] == e_row);
            o_vld[e_bank] = 1'b1; o_row[e_bank] = e_row;
            m_dir = e_wr;
            m_vld[s] = 1'b0;
        end
        if (psh && fr >= 0) begin
            m_vld[fr] = 1'b1; m_bank[fr] = bk; m_row[fr] = rw;
            m_wr[fr] = wr; m_pr[fr] = pr; m_age[fr] = 0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd7391);
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        chk("R1 valid after reset", out_valid, 0);

        // R4: urgent write miss beats older normal read miss
        step(1, 0, 5, 0, 0, 0);
        step(1, 1, 6, 1, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R4 urgent first bank", out_bank, 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R10 closed bank miss", out_miss, 1);
        // R5: younger write hit beats older read miss (dir is read)
        step(1, 2, 1, 0, 0, 0);
        step(1, 0, 5, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R5 hit first bank", out_bank, 0);
        chk("R10 open row hit", out_miss, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R5 miss second bank", out_bank, 2);
        // R6: two hits, last direction read -> read hit first
        step(1, 0, 5, 1, 0, 0);
        step(1, 1, 6, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R6 same-direction hit", out_bank, 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R6 other hit next", out_bank, 0);
        // R7: two misses, last direction write -> read still first
        step(1, 3, 2, 1, 0, 0);
        step(1, 2, 9, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R7 read miss first", out_bank, 2);
        step(0, 0, 0, 0, 0, 1);
        chk("R7 write miss next", out_bank, 3);
        // R8: older entry in higher slot wins over newer in slot 0
        step(1, 3, 3, 0, 1, 0);
        step(1, 0, 7, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R8 urgent drained", out_bank, 3);
        step(1, 1, 8, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R8 older wins bank", out_bank, 0);
        chk("R8 older wins row", out_row, 7);
        drain();
        // R9: normal burst starved by a stream of urgent bursts
        step(1, 0, 11, 1, 0, 0);
        step(1, 1, 20, 0, 1, 0);
        for (int k = 2; k < 16; k++) step(1, 1, 20, 0, 1, 1);
        chk("R9 urgent before limit", out_prio, 1);
        step(1, 1, 20, 0, 1, 1);
        chk("R9 starved bank", out_bank, 0);
        chk("R9 starved row", out_row, 11);
        drain();
        // R2: overfill then drain; dropped push never shows up
        for (int k = 0; k < DEPTH + 1; k++) step(1, k % BANKS, 40 + k, 0, 0, 0);
        chk("R2 full ready low", req_ready, 0);
        for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R2 dropped push not issued", out_valid, 0);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 10) < 6, $urandom % BANKS, $urandom % 4,
                 $urandom % 2, ($urandom % 5) == 0, ($urandom % 2) == 1);
        end
        drain();
        step(0, 0, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule